// File: doc/BRIEF.md
# Specific-Trigger Decision Combiner

This block makes the per-crossing fire/no-fire decision for one specific trigger. On every beam-crossing clock edge it captures its real-time inputs into a register:
- two physics partial and-or terms,
- sixteen exposure-group partial enables,
- eight front-end busy flags,
- four correlated and four decorrelated global disables,
- two individual disables,
- one prescaler disable.

It then reduces these through software-programmed selection masks and obey bits. The results are a trigger-fired output and the intermediate enables that a monitor would record.

A one-shot auto-disable limits the trigger to a single fire after software re-arms it. Software re-arms it by writing a control bit high and then low. A software kill bit blocks the trigger and comes out of reset set. Configuration is loaded through a simple synchronous write port with a 2-bit address and a 16-bit data word. Register contents take effect in the cycle after the write edge.

Top module: `trig_decide`

## Requirements
- R1: Every real-time input is registered on the rising clock edge. The outputs change only after that edge, never while an input moves between edges.
- R2: The exposure enable is the AND of a lower half and an upper half. Register address 0 holds the lower mask in data bits 7:0 and the upper mask in bits 15:8. Each half is the AND of the partial enables whose mask bit is 1, and a half whose mask is all zero counts as enabled.
- R3: Register address 1 holds the busy mask in bits 7:0, the correlated global mask in bits 11:8 and the decorrelated global mask in bits 15:12. Each gated disable is the OR of its inputs whose mask bit is 1, so an all-zero mask gives "not disabled".
- R4: The correlated DAQ enable is high exactly when neither the gated busy disable nor the gated correlated global disable is asserted.
- R5: The decorrelated DAQ enable is low whenever any of the following asserts: the gated decorrelated global disable; an individual disable whose obey bit is set (address 2, bits 1:0); the prescaler disable with obey bit 2 set; the auto-disable with obey bit 3 set; or the kill bit (address 2, bit 8).
- R6: Physics term 0 (lower) is obeyed when address 2 bit 4 is set, and term 1 (upper) when bit 5 is set. A term that is not obeyed counts as true, and the and-or fired output is the AND of the two.
- R7: After reset the kill bit is 1, all masks and obey bits are 0, and the trigger neither fires nor is exposed.
- R8: The trigger-exposed output is the AND of the exposure enable and both DAQ enables. Trigger fired is the trigger-exposed output ANDed with the and-or fired term.
- R9: Writing 1 to address 3 bit 0 forces the auto-disable status high from the next cycle on. A following write of 0 clears it. The first cycle in which the trigger fires then sets it again at the next edge, so a trigger held true fires for exactly one cycle.
- R10: The auto-disable status comes out of reset high. A write of 0 to address 3 bit 0 that is not preceded by a write of 1 leaves it high.
- R11: If the re-arming write of 0 lands on the same edge that closes a cycle in which the trigger fired, the re-arm wins and the status is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 exposure masks, 1 disable masks, 2 obey/kill, 3 auto-disable control) |
| wr_data | input | 16 | Register write data |
| paof_in | input | 2 | Physics partial and-or terms, bit 0 lower, bit 1 upper |
| eg_lo_in | input | 8 | Lower exposure-group partial enables |
| eg_hi_in | input | 8 | Upper exposure-group partial enables |
| busy_in | input | 8 | Front-end busy disables |
| gdis_corr_in | input | 4 | Correlated global disables |
| gdis_decorr_in | input | 4 | Decorrelated global disables |
| ind_dis_in | input | 2 | Individual disables |
| presc_dis_in | input | 1 | Prescaler disable |
| trig_fired | output | 1 | Specific trigger fired |
| trig_exposed | output | 1 | Trigger exposed (exposure and both DAQ enables) |
| andor_fired | output | 1 | Gated physics and-or term |
| expo_en | output | 1 | Exposure-group enable |
| daq_en_corr | output | 1 | Correlated DAQ enable |
| daq_en_decorr | output | 1 | Decorrelated DAQ enable |
| auto_dis | output | 1 | Auto-disable status |

## Verification
Two auto-disable events can meet on one clock edge: the software write of 0 that re-arms the one-shot, and a fire that would set the status again. To provoke this, the bench clears the auto-disable obey bit so that the trigger keeps firing while the reset bit is held high. It then issues the re-arming write. The status must read low right after that edge and high one edge later, once the next fire registers. A separate directed sequence with the obey bit set checks that a trigger held true fires in exactly one cycle after re-arming.

// File: rtl/trig_decide_pkg.sv
package trig_decide_pkg;

    parameter int EG_W   = 8;
    parameter int BUSY_W = 8;
    parameter int GLB_W  = 4;
    parameter int IND_W  = 2;
    parameter int REG_DW = 16;
    parameter int REG_AW = 2;
    parameter int MASK_W = (EG_W > BUSY_W) ? EG_W : BUSY_W;

    localparam logic [REG_AW-1:0] ADDR_EXPO = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_GATE = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_OBEY = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_AUTO = 2'd3;

    localparam int GATE_CORR_LSB   = BUSY_W;
    localparam int GATE_DECORR_LSB = BUSY_W + GLB_W;
    localparam int OB_PRESC = IND_W;
    localparam int OB_AUTO  = IND_W + 1;
    localparam int OB_LO    = IND_W + 2;
    localparam int OB_HI    = IND_W + 3;
    localparam int OB_KILL  = 8;

    typedef struct packed {
        logic [1:0]        paof;
        logic [EG_W-1:0]   eg_lo;
        logic [EG_W-1:0]   eg_hi;
        logic [BUSY_W-1:0] busy;
        logic [GLB_W-1:0]  corr;
        logic [GLB_W-1:0]  decorr;
        logic [IND_W-1:0]  ind;
        logic              presc;
    } rt_in_t;

    typedef struct packed {
        logic [EG_W-1:0]   eg_lo_m;
        logic [EG_W-1:0]   eg_hi_m;
        logic [BUSY_W-1:0] busy_m;
        logic [GLB_W-1:0]  corr_m;
        logic [GLB_W-1:0]  decorr_m;
        logic [IND_W-1:0]  obey_ind;
        logic              obey_presc;
        logic              obey_auto;
        logic              obey_lo;
        logic              obey_hi;
        logic              kill;
    } cfg_t;

    typedef struct packed {
        logic andor;
        logic expo;
        logic corr_en;
        logic decorr_en;
        logic exposed;
        logic fired;
    } dec_t;

    // AND of the selected bits; an empty selection reads as true
    function automatic logic sel_all(input logic [MASK_W-1:0] v,
                                     input logic [MASK_W-1:0] m);
        return &(v | ~m);
    endfunction

    // OR of the selected bits; an empty selection reads as false
    function automatic logic sel_any(input logic [MASK_W-1:0] v,
                                     input logic [MASK_W-1:0] m);
        return |(v & m);
    endfunction

endpackage

// File: rtl/trig_in_latch.sv
module trig_in_latch
    import trig_decide_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  rt_in_t d,
    output rt_in_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_decide_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    output cfg_t              cfg
);
    logic wr_unused;
    assign wr_unused = ^{wr_data[7:OB_HI+1], wr_data[REG_DW-1:OB_KILL+1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            cfg.kill <= 1'b1;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_EXPO: begin
                    cfg.eg_lo_m <= wr_data[EG_W-1:0];
                    cfg.eg_hi_m <= wr_data[2*EG_W-1:EG_W];
                end
                ADDR_GATE: begin
                    cfg.busy_m   <= wr_data[BUSY_W-1:0];
                    cfg.corr_m   <= wr_data[GATE_CORR_LSB +: GLB_W];
                    cfg.decorr_m <= wr_data[GATE_DECORR_LSB +: GLB_W];
                end
                ADDR_OBEY: begin
                    cfg.obey_ind   <= wr_data[IND_W-1:0];
                    cfg.obey_presc <= wr_data[OB_PRESC];
                    cfg.obey_auto  <= wr_data[OB_AUTO];
                    cfg.obey_lo    <= wr_data[OB_LO];
                    cfg.obey_hi    <= wr_data[OB_HI];
                    cfg.kill       <= wr_data[OB_KILL];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/trig_autodis.sv
module trig_autodis (
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr,
    input  logic ctl_bit,
    input  logic fired,
    output logic auto_dis
);
    logic arm_hold_q;
    logic dis_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_hold_q <= 1'b0;
            dis_q      <= 1'b1;
        end else begin
            if (ctl_wr) arm_hold_q <= ctl_bit;
            if (arm_hold_q && ctl_wr && !ctl_bit) dis_q <= 1'b0;
            else if (arm_hold_q)                  dis_q <= 1'b1;
            else if (fired)                       dis_q <= 1'b1;
        end
    end

    assign auto_dis = dis_q | arm_hold_q;
endmodule

// File: rtl/trig_combine.sv
module trig_combine
    import trig_decide_pkg::*;
(
    input  rt_in_t in,
    input  cfg_t   cfg,
    input  logic   auto_dis,
    output dec_t   dec
);
    logic lo_ok, hi_ok, busy_g, corr_g, decorr_g, ind_g, presc_g, auto_g;

    always_comb begin
        lo_ok    = sel_all(MASK_W'(in.eg_lo), MASK_W'(cfg.eg_lo_m));
        hi_ok    = sel_all(MASK_W'(in.eg_hi), MASK_W'(cfg.eg_hi_m));
        busy_g   = sel_any(MASK_W'(in.busy), MASK_W'(cfg.busy_m));
        corr_g   = sel_any(MASK_W'(in.corr), MASK_W'(cfg.corr_m));
        decorr_g = sel_any(MASK_W'(in.decorr), MASK_W'(cfg.decorr_m));
        ind_g    = |(in.ind & cfg.obey_ind);
        presc_g  = in.presc & cfg.obey_presc;
        auto_g   = auto_dis & cfg.obey_auto;

        dec.andor     = (in.paof[0] | ~cfg.obey_lo) & (in.paof[1] | ~cfg.obey_hi);
        dec.expo      = lo_ok & hi_ok;
        dec.corr_en   = ~(busy_g | corr_g);
        dec.decorr_en = ~(decorr_g | ind_g | presc_g | auto_g | cfg.kill);
        dec.exposed   = dec.expo & dec.corr_en & dec.decorr_en;
        dec.fired     = dec.exposed & dec.andor;
    end
endmodule

// File: rtl/trig_decide.sv
module trig_decide
    import trig_decide_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [1:0]        paof_in,
    input  logic [EG_W-1:0]   eg_lo_in,
    input  logic [EG_W-1:0]   eg_hi_in,
    input  logic [BUSY_W-1:0] busy_in,
    input  logic [GLB_W-1:0]  gdis_corr_in,
    input  logic [GLB_W-1:0]  gdis_decorr_in,
    input  logic [IND_W-1:0]  ind_dis_in,
    input  logic              presc_dis_in,
    output logic              trig_fired,
    output logic              trig_exposed,
    output logic              andor_fired,
    output logic              expo_en,
    output logic              daq_en_corr,
    output logic              daq_en_decorr,
    output logic              auto_dis
);
    rt_in_t raw, lat;
    cfg_t   cfg;
    dec_t   dec;

    assign raw = '{paof: paof_in, eg_lo: eg_lo_in, eg_hi: eg_hi_in,
                   busy: busy_in, corr: gdis_corr_in, decorr: gdis_decorr_in,
                   ind: ind_dis_in, presc: presc_dis_in};

    trig_in_latch u_latch (.clk(clk), .rst(rst), .d(raw), .q(lat));

    trig_cfg_regs u_cfg (.clk(clk), .rst(rst), .wr_en(wr_en),
                         .wr_addr(wr_addr), .wr_data(wr_data), .cfg(cfg));

    trig_autodis u_auto (.clk(clk), .rst(rst),
                         .ctl_wr(wr_en && wr_addr == ADDR_AUTO),
                         .ctl_bit(wr_data[0]), .fired(dec.fired),
                         .auto_dis(auto_dis));

    trig_combine u_comb (.in(lat), .cfg(cfg), .auto_dis(auto_dis), .dec(dec));

    assign trig_fired    = dec.fired;
    assign trig_exposed  = dec.exposed;
    assign andor_fired   = dec.andor;
    assign expo_en       = dec.expo;
    assign daq_en_corr   = dec.corr_en;
    assign daq_en_decorr = dec.decorr_en;
endmodule

// File: rtl/trig_decide_chk.sv
module trig_decide_chk
    import trig_decide_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic              wr_bit,
    input logic              trig_fired,
    input logic              trig_exposed,
    input logic              auto_dis
);
    logic ctl_wr;
    logic seen_one_q;
    assign ctl_wr = wr_en && (wr_addr == ADDR_AUTO);

    always_ff @(posedge clk) begin
        if (rst)         seen_one_q <= 1'b0;
        else if (ctl_wr) seen_one_q <= wr_bit;
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (auto_dis && !trig_fired && !trig_exposed)); // R7
    AST_WR1_FORCES: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wr_bit) |=> auto_dis); // R9
    AST_ONE_FIRE: assert property (@(posedge clk) disable iff (rst)
        (trig_fired && !auto_dis && !ctl_wr) |=> auto_dis); // R9
    AST_DIS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (auto_dis && !(ctl_wr && !wr_bit)) |=> auto_dis); // R10
    AST_BARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (auto_dis && !seen_one_q && ctl_wr && !wr_bit) |=> auto_dis); // R10
    AST_REARM_WINS: assert property (@(posedge clk) disable iff (rst)
        (seen_one_q && ctl_wr && !wr_bit) |=> !auto_dis); // R11
    AST_FIRE_EXPOSED: assert property (@(posedge clk) disable iff (rst)
        trig_fired |-> trig_exposed); // R8
endmodule

bind trig_decide trig_decide_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bit(wr_data[0]), .trig_fired(trig_fired),
    .trig_exposed(trig_exposed), .auto_dis(auto_dis)
);

// File: tb/trig_decide_tb.sv
`timescale 1ns/1ps
module trig_decide_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  paof = '0;
    logic [7:0]  eg_lo = '0, eg_hi = '0, busy = '0;
    logic [3:0]  corr = '0, decorr = '0;
    logic [1:0]  ind = '0;
    logic        presc = 1'b0;
    logic trig_fired, trig_exposed, andor_fired, expo_en, daq_en_corr, daq_en_decorr, auto_dis;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trig_decide u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .paof_in(paof), .eg_lo_in(eg_lo), .eg_hi_in(eg_hi), .busy_in(busy),
        .gdis_corr_in(corr), .gdis_decorr_in(decorr), .ind_dis_in(ind),
        .presc_dis_in(presc), .trig_fired(trig_fired), .trig_exposed(trig_exposed),
        .andor_fired(andor_fired), .expo_en(expo_en), .daq_en_corr(daq_en_corr),
        .daq_en_decorr(daq_en_decorr), .auto_dis(auto_dis)
    );

    typedef struct packed {
        logic [15:0] obey, expo, gate;
        logic [1:0]  paof;
        logic [7:0]  eg_lo, eg_hi, busy;
        logic [3:0]  corr, decorr;
        logic [1:0]  ind;
        logic        presc, fired, exposed;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 16'h0000, 16'h0000, 2'b00, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0, 2'b00, 1'b0, 1'b1, 1'b1}, // R3 empty masks
        '{16'h0030, 16'h0000, 16'h0000, 2'b01, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0, 2'b00, 1'b0, 1'b0, 1'b1}, // R6
        '{16'h0030, 16'h0000, 16'h0000, 2'b11, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0, 2'b00, 1'b0, 1'b1, 1'b1}, // R6
        '{16'h0010, 16'h0000, 16'h0000, 2'b01, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0, 2'b00, 1'b0, 1'b1, 1'b1}, // R6
        '{16'h0000, 16'h0003, 16'h0000, 2'b00, 8'h01, 8'h00, 8'h00, 4'h0, 4'h0, 2'b00, 1'b0, 1'b0, 1'b0}, // R2
        '{16'h0000, 16'h0003, 16'h0000, 2'b00, 8'h03, 8'h00, 8'h00, 4'h0, 4'h0, 2'b00, 1'b0, 1'b1, 1'b1}, // R2
        '{16'h0000, 16'h8000, 16'h0000, 2'b00, 8'h00, 8'h7F, 8'h00, 4'h0, 4'h0, 2'b00, 1'b0, 1'b0, 1'b0}, // R2
        '{16'h0000, 16'h0000, 16'h0004, 2'b00, 8'h00, 8'h00, 8'h04, 4'h0, 4'h0, 2'b00, 1'b0, 1'b0, 1'b0}, // R4
        '{16'h0000, 16'h0000, 16'h00FB, 2'b00, 8'h00, 8'h00, 8'h04, 4'h0, 4'h0, 2'b00, 1'b0, 1'b1, 1'b1}, // R3
        '{16'h0000, 16'h0000, 16'h0200, 2'b00, 8'h00, 8'h00, 8'h00, 4'h2, 4'h0, 2'b00, 1'b0, 1'b0, 1'b0}, // R4
        '{16'h0000, 16'h0000, 16'h4000, 2'b00, 8'h00, 8'h00, 8'h00, 4'h0, 4'h4, 2'b00, 1'b0, 1'b0, 1'b0}, // R5
        '{16'h0000, 16'h0000, 16'h2000, 2'b00, 8'h00, 8'h00, 8'h00, 4'h0, 4'h4, 2'b00, 1'b0, 1'b1, 1'b1}, // R5
        '{16'h0002, 16'h0000, 16'h0000, 2'b00, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0, 2'b10, 1'b0, 1'b0, 1'b0}, // R5
        '{16'h0001, 16'h0000, 16'h0000, 2'b00, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0, 2'b10, 1'b0, 1'b1, 1'b1}, // R5
        '{16'h0004, 16'h0000, 16'h0000, 2'b00, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0, 2'b00, 1'b1, 1'b0, 1'b0}, // R5
        '{16'h0000, 16'h0000, 16'h0000, 2'b00, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0, 2'b00, 1'b1, 1'b1, 1'b1}, // R5
        '{16'h0100, 16'h0000, 16'h0000, 2'b00, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0, 2'b00, 1'b0, 1'b0, 1'b0}, // R7 kill
        '{16'h0000, 16'h0000, 16'h0000, 2'b00, 8'hFF, 8'hFF, 8'hFF, 4'hF, 4'hF, 2'b11, 1'b1, 1'b1, 1'b1}  // R3 inputs ignored
    };

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic zero_inputs();
        paof = '0; eg_lo = '0; eg_hi = '0; busy = '0;
        corr = '0; decorr = '0; ind = '0; presc = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(trig_fired, 1'b0, "R7 fired after reset");
        check(trig_exposed, 1'b0, "R7 exposed after reset");
        check(auto_dis, 1'b1, "R10 auto_dis after reset");

        // Table walk: auto-disable not obeyed, so its state does not matter
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, VEC[i].expo);
            wr(2'd1, VEC[i].gate);
            wr(2'd2, VEC[i].obey);
            paof = VEC[i].paof; eg_lo = VEC[i].eg_lo; eg_hi = VEC[i].eg_hi;
            busy = VEC[i].busy; corr = VEC[i].corr; decorr = VEC[i].decorr;
            ind = VEC[i].ind; presc = VEC[i].presc;
            @(negedge clk);
            check(trig_fired, VEC[i].fired, $sformatf("R8 fired vector %0d", i));
            check(trig_exposed, VEC[i].exposed, $sformatf("R8 exposed vector %0d", i));
        end

        // R1: input change between edges is not seen until the edge
        zero_inputs();
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0001);
        wr(2'd2, 16'h0000);
        @(negedge clk);
        check(daq_en_corr, 1'b1, "R1 corr enable before busy");
        busy = 8'h01;
        #1;
        check(daq_en_corr, 1'b1, "R1 busy not seen before edge");
        @(negedge clk);
        check(daq_en_corr, 1'b0, "R1 busy seen after edge");
        check(trig_fired, 1'b0, "R4 busy blocks fire");
        zero_inputs();
        wr(2'd1, 16'h0000);

        // R10: bare zero write does not re-arm
        wr(2'd2, 16'h0008);
        check(auto_dis, 1'b1, "R10 still disabled");
        check(trig_fired, 1'b0, "R5 obeyed auto blocks fire");
        wr(2'd3, 16'h0000);
        check(auto_dis, 1'b1, "R10 bare zero ignored");
        check(trig_fired, 1'b0, "R10 no fire after bare zero");

        // R9: write 1 forces, 1->0 re-arms, exactly one fire
        wr(2'd3, 16'h0001);
        check(auto_dis, 1'b1, "R9 write one forces");
        check(trig_fired, 1'b0, "R9 no fire while forced");
        wr(2'd3, 16'h0000);
        check(auto_dis, 1'b0, "R9 re-armed");
        check(trig_fired, 1'b1, "R9 single fire");
        @(negedge clk);
        check(auto_dis, 1'b1, "R9 re-asserted after fire");
        check(trig_fired, 1'b0, "R9 second cycle blocked");
        repeat (5) @(negedge clk);
        check(trig_fired, 1'b0, "R9 stays blocked");

        // R11: re-arm and fire on the same edge, auto not obeyed
        wr(2'd2, 16'h0000);
        check(trig_fired, 1'b1, "R11 fires when auto not obeyed");
        wr(2'd3, 16'h0001);
        check(trig_fired, 1'b1, "R11 fire during forced state");
        wr(2'd3, 16'h0000);
        check(auto_dis, 1'b0, "R11 re-arm wins over fire");
        @(negedge clk);
        check(auto_dis, 1'b1, "R11 next fire sets status");

        // R7: reset mid-run restores the kill bit
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(trig_fired, 1'b0, "R7 kill after second reset");
        check(daq_en_decorr, 1'b0, "R7 decorr enable low after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule